// File: doc/BRIEF.md
# USB Device Global Interrupt Status

This block collects the bus-level events of a full-speed USB device controller into one set of sticky status flags and turns them into a single interrupt request for the processor. The packet decoder and the line-state logic supply the event inputs. One input marks the end of a bus reset. One marks a detected start-of-frame token. One shows that the line is idle in the J state. One shows non-idle activity on the line. A free-running 1 ms tick is the time base.

The block contains its own idle-bus timer. When the line has stayed in J for three frame periods, the suspend flag is raised. The controller is then treated as suspended until software clears that flag. The wake flag can only be raised while the controller is suspended, and only by line activity that the device is not driving itself as a resume.

Software sees an 8-bit status word and an 8-bit enable word. It clears a flag by writing a 1 to that flag's bit. The interrupt output is a registered OR of every flag whose enable bit is set.

Top module: `usb_irq_status`

## Requirements
- R1: After reset, status_o, enable_o and irq_o are all 0.
- R2: The four flags sit at fixed bit positions in status_o and enable_o: suspend at bit 0, start-of-frame at bit 3, end-of-reset at bit 4 and wake at bit 5. Bits 1, 2, 6 and 7 always read 0, and writes to them have no effect in either word.
- R3: A pulse on bus_reset_end_i sets status bit 4 at the next clock edge.
- R4: A pulse on sof_pid_i sets status bit 3 at the next clock edge.
- R5: Status bit 0 is set at the edge of the third tick_1ms_i pulse counted while line_j_i stays 1. Any cycle with line_j_i at 0 restarts the count. After the flag has been raised, it is not raised again until line_j_i has gone to 0.
- R6: Status bit 5 is set at an edge only if status bit 0 is 1 and line_active_i is 1 and dev_resume_i is 0 in that cycle.
- R7: A flag stays set until a cycle with wr_en_i at 1 and a 1 in that flag's bit of wr_data_i. Writing 0 to a flag's bit leaves it unchanged.
- R8: If a hardware set and a software clear of the same flag fall in one cycle, the flag ends up set.
- R9: irq_o equals, one cycle later, the OR over the four flags of (flag AND enable bit). The enable word is loaded from en_data_i when en_wr_i is 1.
- R10: suspended_o follows status bit 0. Once software clears the suspend flag, line activity no longer sets the wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1ms_i | input | 1 | One-cycle pulse every millisecond |
| line_j_i | input | 1 | Line is idle in the J state |
| line_active_i | input | 1 | Non-idle signalling is seen on the line |
| dev_resume_i | input | 1 | The device itself is driving resume signalling |
| bus_reset_end_i | input | 1 | One-cycle pulse at the end of a bus reset |
| sof_pid_i | input | 1 | One-cycle pulse when a start-of-frame token is decoded |
| wr_en_i | input | 1 | Write-one-to-clear strobe for the status word |
| wr_data_i | input | 8 | Bit mask of flags to clear |
| en_wr_i | input | 1 | Load strobe for the enable word |
| en_data_i | input | 8 | New enable word |
| status_o | output | 8 | Status flags |
| enable_o | output | 8 | Enable word |
| suspended_o | output | 1 | The controller is in the suspended state |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The main collision is a hardware event and a software clear of the same flag landing on one edge. The bench provokes this by pulsing the start-of-frame strobe in the same cycle as a write-one to bit 3. It passes only if the flag reads 1 after that edge. The second collision is the wake condition against the suspended state. Line activity is applied once with the device's own resume active, once while suspended, and once after the suspend flag has been cleared. Only the middle case may set bit 5.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned FLAG_N = 4;

  // flag index -> bit position in the status word (layout decoded by software)
  localparam int unsigned IDX_SUSP = 0;
  localparam int unsigned IDX_SOF  = 1;
  localparam int unsigned IDX_EOR  = 2;
  localparam int unsigned IDX_WAKE = 3;

  localparam int unsigned FLAG_POS [FLAG_N] = '{0, 3, 4, 5};

  localparam logic [REG_W-1:0] FLAG_MASK = 8'h39;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned IDLE_MS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_i,
  output logic det_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_MS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_MS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!idle_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // fires once per idle stretch; counter then parks at CNT_MAX
  assign det_o = idle_i && tick_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // set beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int unsigned IDLE_MS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_1ms_i,
  input  logic             line_j_i,
  input  logic             line_active_i,
  input  logic             dev_resume_i,
  input  logic             bus_reset_end_i,
  input  logic             sof_pid_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             en_wr_i,
  input  logic [REG_W-1:0] en_data_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] enable_o,
  output logic             suspended_o,
  output logic             irq_o
);
  logic              susp_det;
  logic [FLAG_N-1:0] set_v, clr_v, flag_q;
  logic [REG_W-1:0]  en_q;
  logic              irq_q;

  usb_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_1ms_i),
    .idle_i (line_j_i),
    .det_o  (susp_det)
  );

  always_comb begin
    set_v           = '0;
    set_v[IDX_SUSP] = susp_det;
    set_v[IDX_SOF]  = sof_pid_i;
    set_v[IDX_EOR]  = bus_reset_end_i;
    set_v[IDX_WAKE] = flag_q[IDX_SUSP] & line_active_i & ~dev_resume_i;
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_map
    assign clr_v[i] = wr_en_i & wr_data_i[FLAG_POS[i]];
  end

  usb_irq_flags #(.N(FLAG_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .flag_o (flag_q)
  );

  always_comb begin
    status_o = '0;
    for (int i = 0; i < FLAG_N; i++) status_o[FLAG_POS[i]] = flag_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (en_wr_i) en_q <= en_data_i & FLAG_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_o & en_q);
  end

  assign enable_o    = en_q;
  assign suspended_o = flag_q[IDX_SUSP];
  assign irq_o       = irq_q;
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
  import usb_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_1ms_i,
  input logic             line_j_i,
  input logic             line_active_i,
  input logic             dev_resume_i,
  input logic             bus_reset_end_i,
  input logic             sof_pid_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] status_o,
  input logic [REG_W-1:0] enable_o,
  input logic             suspended_o,
  input logic             irq_o
);
  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~FLAG_MASK) == '0) && ((enable_o & ~FLAG_MASK) == '0));

  assert_eor_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_end_i |=> status_o[4]);

  assert_sof_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_pid_i |=> status_o[3]);

  assert_susp_needs_j_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(line_j_i && tick_1ms_i));

  assert_wake_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> $past(status_o[0] && line_active_i && !dev_resume_i));

  assert_sof_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !(wr_en_i && wr_data_i[3])) |=> status_o[3]);

  assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(status_o & enable_o)));

  assert_suspended_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o == status_o[0]);
endmodule

bind usb_irq_status usb_irq_status_chk u_chk (.*);

// File: tb/usb_irq_status_bench.sv
module usb_irq_status_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_1ms_i = 0, line_j_i = 0, line_active_i = 0, dev_resume_i = 0;
  logic       bus_reset_end_i = 0, sof_pid_i = 0, wr_en_i = 0, en_wr_i = 0;
  logic [7:0] wr_data_i = 0, en_data_i = 0;
  logic [7:0] status_o, enable_o;
  logic       suspended_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  usb_irq_status u_usb_irq_status (.*);

  // {sof, eor, wr_en, wr_data, expected status after the edge}
  typedef struct packed {
    logic       sof;
    logic       eor;
    logic       wr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'h08},  // R4
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h08},  // R7 sticky
    '{1'b0, 1'b0, 1'b1, 8'h08, 8'h00},  // R7 clear
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h10},  // R3
    '{1'b1, 1'b0, 1'b1, 8'h10, 8'h08},
    '{1'b1, 1'b0, 1'b1, 8'h08, 8'h08},  // R8 set wins
    '{1'b0, 1'b0, 1'b1, 8'hF7, 8'h08},  // R2 reserved writes
    '{1'b0, 1'b0, 1'b1, 8'hFF, 8'h00},
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h18},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h18},  // R7 write zero
    '{1'b0, 1'b0, 1'b1, 8'h18, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle: inputs held from this negedge to the next
  task automatic step();
    @(negedge clk_i);
    tick_1ms_i = 0; sof_pid_i = 0; bus_reset_end_i = 0;
    wr_en_i = 0; wr_data_i = 0; en_wr_i = 0; line_active_i = 0; dev_resume_i = 0;
  endtask

  task automatic tick();
    tick_1ms_i = 1; @(negedge clk_i); tick_1ms_i = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 status", status_o, 8'h00);
    chk("R1 enable", enable_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    foreach (VECS[i]) begin
      sof_pid_i = VECS[i].sof; bus_reset_end_i = VECS[i].eor;
      wr_en_i = VECS[i].wr; wr_data_i = VECS[i].data;
      step();
      chk($sformatf("R7/R8 vec%0d", i), status_o, VECS[i].exp);
    end

    // R2 enable word layout
    en_wr_i = 1; en_data_i = 8'hFF; step();
    chk("R2 enable mask", enable_o, 8'h39);
    // R9 irq only through enabled flag, one cycle late
    en_wr_i = 1; en_data_i = 8'h08; step();
    bus_reset_end_i = 1; step(); step();
    chk("R9 masked eor", {7'b0, irq_o}, 8'h00);
    sof_pid_i = 1; step();
    chk("R9 irq delay", {7'b0, irq_o}, 8'h00);
    step();
    chk("R9 irq set", {7'b0, irq_o}, 8'h01);
    wr_en_i = 1; wr_data_i = 8'h18; step();
    chk("R9 irq hold", {7'b0, irq_o}, 8'h01);
    step();
    chk("R9 irq clear", {7'b0, irq_o}, 8'h00);

    // R5 idle timer with restart
    line_j_i = 1;
    tick(); step(); tick(); step();
    chk("R5 two ticks", status_o, 8'h00);
    line_j_i = 0; step(); line_j_i = 1;
    tick(); step(); tick(); step();
    chk("R5 restart", status_o, 8'h00);
    tick();
    chk("R5 third tick", status_o, 8'h01);
    chk("R10 suspended", {7'b0, suspended_o}, 8'h01);

    // R6 wake qualification
    line_active_i = 1; dev_resume_i = 1; step();
    chk("R6 own resume", status_o, 8'h01);
    line_active_i = 1; step();
    chk("R6 wake", status_o, 8'h21);
    wr_en_i = 1; wr_data_i = 8'h21; step();
    chk("R10 cleared", {7'b0, suspended_o}, 8'h00);
    tick(); step(); tick(); step(); tick(); step(); tick(); step();
    chk("R5 no repeat", status_o, 8'h00);
    line_active_i = 1; step();
    chk("R10 no wake", status_o, 8'h00);

    line_j_i = 0; step(); line_j_i = 1;
    tick(); tick(); tick();
    chk("R5 rearmed", status_o, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule